// File: doc/BRIEF.md
# Low-Power Host Access Gate

This block sits between the host bus decoder and the device's internal registers and memories. It catches a host request to enter low-power mode, in either of two bus personalities: a PC-card personality and a plug-and-play ISA personality. It turns that request into a sticky interrupt bit for the embedded controller. The controller alone decides whether to power down. The timing of the power-down interval and the clock gating are handled elsewhere. This block only sees a `pdn_active` status.

While `pdn_active` is high, the block judges every host access by its decoded target class. A target that stays powered is forwarded to the target as usual. Any other access is refused at the gate. It returns all-ones read data and a one-cycle blocked flag, and a write to it is dropped. A card-information read in PC-card mode is served normally, and it also raises a one-cycle wake request. Each host strobe is answered one cycle later on a registered response.

Top module: `lpm_host_gate`

Target class encoding on `hst_tgt`:
- 0: card option register
- 1: card status register
- 2 to 5: interface registers 0 to 3
- 6 to 9: interface registers 4 to 7, which are the windows to memory
- 10: memory window
- 11: plug-and-play register
- 12: card-information memory
- 13 to 15: other core registers

## Requirements
- R1: After reset, `rsp_valid`, `rsp_blocked`, `wake_req` and `pd_irq` are 0, and `rsp_rdata` is 0.
- R2: While `pdn_active` is 0, every strobe to every target class 0 to 15 is forwarded. Forwarded means `fwd_stb`=1 in the same cycle, and `rsp_blocked`=0 one cycle later.
- R3: In PC-card mode (`isa_mode`=0), a host write to class 1 with data bit 2 set makes `pd_irq` read 1 one cycle later. The same write in ISA mode, or with bit 2 clear, leaves `pd_irq` unchanged.
- R4: In ISA mode (`isa_mode`=1), a host write to class 5 with data bit 7 set makes `pd_irq` read 1 one cycle later. The same write in PC-card mode, or with bit 7 clear, leaves `pd_irq` unchanged.
- R5: `pd_irq` stays 1 until a cycle with `ctl_irq_clr`=1 clears it. When a new request and a clear fall in the same cycle, the request wins and `pd_irq` stays 1.
- R6: In PC-card mode with `pdn_active`=1, these accesses are forwarded and all others are blocked:
  - reads and writes to classes 0 to 5;
  - reads of class 12.
- R7: In ISA mode with `pdn_active`=1, only classes 2 to 5 are forwarded. Class 11 and class 12 are blocked.
- R8: With `pdn_active`=1, classes 6 to 10 are blocked in both modes.
- R9: A blocked access behaves as follows:
  - `fwd_stb` stays 0, so a blocked write never reaches a target.
  - One cycle later `rsp_valid`=1, `rsp_blocked`=1 and `rsp_rdata` is all ones.
  - `rsp_blocked` returns to 0 in the following cycle when no strobe is given.
- R10: A read of class 12 in PC-card mode with `pdn_active`=1 gives `wake_req`=1 for one cycle, together with a normal served response. A read of class 12 while powered up, or a write to class 12, gives no wake.
- R11: A served read returns, one cycle later, the `tgt_rdata` that was present in the strobe cycle. A served write returns `rsp_rdata`=0. `fwd_wdata` equals `hst_wdata` when the access is forwarded and is 0 when it is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| isa_mode | input | 1 | 0 selects the PC-card personality, 1 selects plug-and-play ISA |
| pdn_active | input | 1 | Device is currently powered down |
| hst_stb | input | 1 | Host access strobe, one cycle per access |
| hst_we | input | 1 | 1 for a write access, 0 for a read |
| hst_tgt | input | 4 | Decoded target class |
| hst_wdata | input | DW | Host write data |
| tgt_rdata | input | DW | Read data from the addressed target, valid in the strobe cycle |
| ctl_irq_clr | input | 1 | Controller writes 1 to clear the request interrupt |
| fwd_stb | output | 1 | Strobe passed on to the target |
| fwd_we | output | 1 | Write qualifier passed on to the target |
| fwd_wdata | output | DW | Write data passed on to the target, 0 when not forwarded |
| rsp_valid | output | 1 | Registered response strobe |
| rsp_blocked | output | 1 | The answered access was refused |
| rsp_rdata | output | DW | Registered read data |
| wake_req | output | 1 | One-cycle power-down exit request |
| pd_irq | output | 1 | Sticky power-down request interrupt to the controller |

## Verification
Two functions can fall in the same cycle: a new power-down request and the controller's clear of the interrupt bit. The bench provokes this by giving a write with the request bit set to the status register and `ctl_irq_clr` in the same cycle. It then judges that `pd_irq` still reads 1, so the request is not lost. The bench also sweeps all target classes across both modes, both power states and both access directions, and computes the expected forward, block and wake result from the reachability rules.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int TW = 4;

  typedef enum logic [TW-1:0] {
    TGT_CFG_OPT = 4'd0,
    TGT_CFG_STS = 4'd1,
    TGT_SIF0    = 4'd2,
    TGT_SIF3    = 4'd5,
    TGT_SIF4    = 4'd6,
    TGT_SIF7    = 4'd9,
    TGT_MEM_WIN = 4'd10,
    TGT_PNP     = 4'd11,
    TGT_CIS     = 4'd12
  } tgt_e;

  // Served while powered down?
  function automatic logic tgt_reachable(input logic isa, input logic pd,
                                         input logic we, input logic [TW-1:0] t);
    logic r;
    if (!pd) r = 1'b1;
    else if (isa) r = (t >= TGT_SIF0) && (t <= TGT_SIF3);
    else r = (t <= TGT_SIF3) || ((t == TGT_CIS) && !we);
    return r;
  endfunction

  // Card-information read that forces power-down exit.
  function automatic logic tgt_wakes(input logic isa, input logic pd,
                                     input logic we, input logic [TW-1:0] t);
    return pd && !isa && !we && (t == TGT_CIS);
  endfunction

  // Memory path (interface regs 4..7 or window).
  function automatic logic tgt_is_mem(input logic [TW-1:0] t);
    return (t >= TGT_SIF4) && (t <= TGT_MEM_WIN);
  endfunction
endpackage

// File: rtl/lpm_reach_dec.sv
module lpm_reach_dec
  import lpm_pkg::*;
#(
  parameter int DW       = 8,
  parameter int CSTS_BIT = 2,
  parameter int SIF3_BIT = 7
) (
  input  logic          isa_mode,
  input  logic          pdn_active,
  input  logic          hst_stb,
  input  logic          hst_we,
  input  logic [TW-1:0] hst_tgt,
  input  logic [DW-1:0] hst_wdata,
  output logic          fwd_ev,
  output logic          blk_ev,
  output logic          wake_ev,
  output logic          req_ev
);
  logic reach;
  logic pc_req, isa_req;

  always_comb begin
    reach   = tgt_reachable(isa_mode, pdn_active, hst_we, hst_tgt);
    fwd_ev  = hst_stb && reach;
    blk_ev  = hst_stb && !reach;
    wake_ev = hst_stb && tgt_wakes(isa_mode, pdn_active, hst_we, hst_tgt);
    pc_req  = !isa_mode && (hst_tgt == TGT_CFG_STS) && hst_wdata[CSTS_BIT];
    isa_req = isa_mode && (hst_tgt == TGT_SIF3) && hst_wdata[SIF3_BIT];
    req_ev  = fwd_ev && hst_we && (pc_req || isa_req);
  end
endmodule

// File: rtl/lpm_req_latch.sv
module lpm_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic req_ev,
  input  logic clr_ev,
  output logic pd_irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) pd_irq <= 1'b0;
    else if (req_ev) pd_irq <= 1'b1;
    else if (clr_ev) pd_irq <= 1'b0;
  end

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ev |=> pd_irq); // R3
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_irq && !clr_ev) |=> pd_irq); // R5
  AST_IRQ_NOSPUR: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_irq && !req_ev) |=> !pd_irq); // R4
endmodule

// File: rtl/lpm_rsp_stage.sv
module lpm_rsp_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwd_ev,
  input  logic          blk_ev,
  input  logic          wake_ev,
  input  logic          rd_ev,
  input  logic [DW-1:0] tgt_rdata,
  output logic          rsp_valid,
  output logic          rsp_blocked,
  output logic [DW-1:0] rsp_rdata,
  output logic          wake_req
);
  localparam logic [DW-1:0] BLK_FILL = {DW{1'b1}};

  logic [DW-1:0] rdata_nx;

  always_comb begin
    if (blk_ev) rdata_nx = BLK_FILL;
    else if (fwd_ev && rd_ev) rdata_nx = tgt_rdata;
    else rdata_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_blocked <= 1'b0;
      rsp_rdata   <= '0;
      wake_req    <= 1'b0;
    end else begin
      rsp_valid   <= fwd_ev || blk_ev;
      rsp_blocked <= blk_ev;
      rsp_rdata   <= rdata_nx;
      wake_req    <= wake_ev;
    end
  end

  AST_BLK_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_blocked |-> (rsp_valid && (rsp_rdata == BLK_FILL))); // R9
  AST_BLK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    blk_ev |=> rsp_blocked); // R9
  AST_WAKE_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (rsp_valid && !rsp_blocked)); // R10
endmodule

// File: rtl/lpm_host_gate.sv
module lpm_host_gate
  import lpm_pkg::*;
#(
  parameter int DW       = 8,
  parameter int CSTS_BIT = 2,
  parameter int SIF3_BIT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          isa_mode,
  input  logic          pdn_active,
  input  logic          hst_stb,
  input  logic          hst_we,
  input  logic [TW-1:0] hst_tgt,
  input  logic [DW-1:0] hst_wdata,
  input  logic [DW-1:0] tgt_rdata,
  input  logic          ctl_irq_clr,
  output logic          fwd_stb,
  output logic          fwd_we,
  output logic [DW-1:0] fwd_wdata,
  output logic          rsp_valid,
  output logic          rsp_blocked,
  output logic [DW-1:0] rsp_rdata,
  output logic          wake_req,
  output logic          pd_irq
);
  initial begin
    if (CSTS_BIT >= DW || SIF3_BIT >= DW) $error("request bit outside data width");
  end

  logic fwd_ev, blk_ev, wake_ev, req_ev;

  lpm_reach_dec #(.DW(DW), .CSTS_BIT(CSTS_BIT), .SIF3_BIT(SIF3_BIT)) u_dec (
    .isa_mode(isa_mode), .pdn_active(pdn_active), .hst_stb(hst_stb),
    .hst_we(hst_we), .hst_tgt(hst_tgt), .hst_wdata(hst_wdata),
    .fwd_ev(fwd_ev), .blk_ev(blk_ev), .wake_ev(wake_ev), .req_ev(req_ev));

  assign fwd_stb   = fwd_ev;
  assign fwd_we    = fwd_ev && hst_we;
  assign fwd_wdata = fwd_we ? hst_wdata : '0;

  lpm_req_latch u_irq (
    .clk(clk), .rst_n(rst_n), .req_ev(req_ev), .clr_ev(ctl_irq_clr),
    .pd_irq(pd_irq));

  lpm_rsp_stage #(.DW(DW)) u_rsp (
    .clk(clk), .rst_n(rst_n), .fwd_ev(fwd_ev), .blk_ev(blk_ev),
    .wake_ev(wake_ev), .rd_ev(!hst_we), .tgt_rdata(tgt_rdata),
    .rsp_valid(rsp_valid), .rsp_blocked(rsp_blocked),
    .rsp_rdata(rsp_rdata), .wake_req(wake_req));

  AST_AWAKE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_stb && !pdn_active) |-> fwd_stb); // R2
  AST_ISA_PNP_BLK: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_stb && isa_mode && pdn_active && hst_tgt == TGT_PNP) |-> !fwd_stb); // R7
  AST_MEM_BLK: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_stb && pdn_active && tgt_is_mem(hst_tgt)) |-> !fwd_stb); // R8
  AST_PC_CFG_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_stb && !isa_mode && hst_tgt <= TGT_SIF3) |-> fwd_stb); // R6
  AST_STROBE_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    hst_stb |=> rsp_valid); // R11
endmodule

// File: tb/sim_lpm_host_gate.sv
`timescale 1ns/1ps
module sim_lpm_host_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic isa_mode = 1'b0, pdn_active = 1'b0, hst_stb = 1'b0, hst_we = 1'b0;
  logic [3:0] hst_tgt = '0;
  logic [7:0] hst_wdata = '0;
  logic [7:0] tgt_rdata;
  logic ctl_irq_clr = 1'b0;
  logic fwd_stb, fwd_we, rsp_valid, rsp_blocked, wake_req, pd_irq;
  logic [7:0] fwd_wdata, rsp_rdata;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] pat(input logic [3:0] t);
    return {t, ~t};
  endfunction
  assign tgt_rdata = pat(hst_tgt);

  lpm_host_gate u0 (
    .clk(clk), .rst_n(rst_n), .isa_mode(isa_mode), .pdn_active(pdn_active),
    .hst_stb(hst_stb), .hst_we(hst_we), .hst_tgt(hst_tgt), .hst_wdata(hst_wdata),
    .tgt_rdata(tgt_rdata), .ctl_irq_clr(ctl_irq_clr), .fwd_stb(fwd_stb),
    .fwd_we(fwd_we), .fwd_wdata(fwd_wdata), .rsp_valid(rsp_valid),
    .rsp_blocked(rsp_blocked), .rsp_rdata(rsp_rdata), .wake_req(wake_req),
    .pd_irq(pd_irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reachability restated from the requirements text.
  function automatic bit exp_reach(bit isa, bit pd, bit we, int t);
    if (!pd) return 1;
    if (t >= 6 && t <= 10) return 0;
    if (isa) return (t >= 2 && t <= 5);
    return (t <= 5) || (t == 12 && !we);
  endfunction

  function automatic string tag(bit isa, bit pd, bit we, int t);
    if (!pd) return "R2";
    if (t >= 6 && t <= 10) return "R8";
    if (t == 12 && !isa) return "R10";
    return isa ? "R7" : "R6";
  endfunction

  task automatic access(bit isa, bit pd, bit we, int t, logic [7:0] wd, bit clr,
                        output bit served);
    string r;
    bit ok;
    bit wk;
    ok = exp_reach(isa, pd, we, t);
    wk = pd && !isa && !we && t == 12;
    r = tag(isa, pd, we, t);
    @(negedge clk);
    isa_mode = isa; pdn_active = pd; hst_stb = 1; hst_we = we;
    hst_tgt = 4'(t); hst_wdata = wd; ctl_irq_clr = clr;
    #1;
    chk(r, {31'd0, fwd_stb}, {31'd0, ok});
    chk("R11", {24'd0, fwd_wdata}, (ok && we) ? {24'd0, wd} : 32'd0);
    @(posedge clk); #1;
    hst_stb = 0; ctl_irq_clr = 0;
    chk("R11", {31'd0, rsp_valid}, 32'd1);
    chk(ok ? r : "R9", {31'd0, rsp_blocked}, {31'd0, !ok});
    chk(ok ? "R11" : "R9", {24'd0, rsp_rdata},
        !ok ? 32'hFF : (we ? 32'd0 : {24'd0, pat(4'(t))}));
    chk("R10", {31'd0, wake_req}, {31'd0, wk});
    served = ok;
  endtask

  task automatic idle();
    @(negedge clk); @(posedge clk); #1;
  endtask

  initial begin
    bit s;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", {28'd0, rsp_valid, rsp_blocked, wake_req, pd_irq}, 32'd0);
    chk("R1", {24'd0, rsp_rdata}, 32'd0);
    @(negedge clk); rst_n = 1;
    // Full sweep; 8'h5A has bits 2 and 7 clear, so no request.
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 2; p++)
        for (int w = 0; w < 2; w++)
          for (int t = 0; t < 16; t++) begin
            access(m[0], p[0], w[0], t, 8'h5A, 0, s);
            if (!s) begin
              idle();
              chk("R9", {31'd0, rsp_blocked}, 32'd0);
            end
          end
    chk("R3", {31'd0, pd_irq}, 32'd0);
    // R3 mode and bit checks
    access(1, 0, 1, 1, 8'h04, 0, s);
    chk("R3", {31'd0, pd_irq}, 32'd0);
    access(0, 0, 1, 1, 8'hFB, 0, s);
    chk("R3", {31'd0, pd_irq}, 32'd0);
    access(0, 1, 1, 1, 8'h04, 0, s);
    chk("R3", {31'd0, pd_irq}, 32'd1);
    repeat (5) idle();
    chk("R5", {31'd0, pd_irq}, 32'd1);
    @(negedge clk); ctl_irq_clr = 1; @(posedge clk); #1; ctl_irq_clr = 0;
    chk("R5", {31'd0, pd_irq}, 32'd0);
    // R4 checks
    access(0, 0, 1, 5, 8'h80, 0, s);
    chk("R4", {31'd0, pd_irq}, 32'd0);
    access(1, 1, 1, 5, 8'h7F, 0, s);
    chk("R4", {31'd0, pd_irq}, 32'd0);
    access(1, 1, 1, 5, 8'h80, 0, s);
    chk("R4", {31'd0, pd_irq}, 32'd1);
    // R5: request and clear together, request wins
    @(negedge clk); ctl_irq_clr = 1; @(posedge clk); #1; ctl_irq_clr = 0;
    chk("R5", {31'd0, pd_irq}, 32'd0);
    access(0, 0, 1, 1, 8'h04, 1, s);
    chk("R5", {31'd0, pd_irq}, 32'd1);
    // R10: wake is a single-cycle pulse
    access(0, 1, 0, 12, 8'h00, 0, s);
    idle();
    chk("R10", {31'd0, wake_req}, 32'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule